// File: doc/BRIEF.md
# Accumulator/MQ Iterative Multiply-Divide Unit

This block is a sequential signed-integer multiply and divide engine built around two architectural registers: an accumulator (AC) and a multiplier/quotient register (MQ), each `W` bits wide (40 by default). A controller issues an operation with a one-cycle `start` pulse, a 2-bit `op` code and a `W`-bit memory operand. Two single-cycle operations load AC or MQ from the operand. The two long operations run one shift step per clock for exactly `W` steps.

Multiply treats MQ as the multiplier and the operand as the multiplicand. The double-length signed product is returned with its upper half in AC and its lower half in MQ. Divide takes AC (high) concatenated with MQ (low) as a double-length signed dividend and divides it by the operand. The quotient goes to MQ and the remainder to AC. Both operations work on magnitudes: shift-and-add for multiply and restoring shift-and-subtract for divide. Signs are applied in a final correction step. A zero divisor, or a quotient that does not fit the signed `W`-bit range, raises `ovf` and leaves AC and MQ untouched.

The controller has four states:
- IDLE waits for `start`. A load operation goes to DONE; a multiply or divide goes to RUN.
- RUN performs one iteration per cycle and moves to FIX after its `W`-th step.
- FIX applies the sign correction, writes AC/MQ/ovf, and moves to DONE.
- DONE raises `done` for one cycle and returns to IDLE.

Top module: `acmq_muldiv`

## Requirements
- R1: After reset, `ac`, `mq`, `busy`, `done` and `ovf` are all 0.
- R2: `op`=0 writes the operand into AC and `op`=1 writes it into MQ. In both cases `done` is seen in the first cycle after the start edge.
- R3: `op`=2 (multiply) places the signed product MQ × operand in {AC,MQ}, with AC holding the upper `W` bits and MQ the lower `W` bits, and clears `ovf`.
- R4: `op`=3 (divide) with a valid divisor places the signed quotient of {AC,MQ} ÷ operand, truncated toward zero, in MQ. It places the remainder, which carries the dividend's sign, in AC, and clears `ovf`.
- R5: A divide whose divisor is zero, or whose quotient falls outside [−2^(W−1), 2^(W−1)−1], sets `ovf` and leaves AC and MQ unchanged.
- R6: For multiply and divide, `busy` is high from the cycle after the start edge, and `done` appears `W`+2 cycles after that edge.
- R7: `done` lasts exactly one cycle, and `busy` is high whenever `done` is high.
- R8: A `start` pulse that arrives while `busy` is high is ignored.
- R9: `ovf` changes only in a `done` cycle, and load operations do not alter it.
- R10: While busy and before `done`, `ac` and `mq` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, sampled while idle |
| op | input | 2 | 0 load AC, 1 load MQ, 2 multiply, 3 divide |
| operand | input | W | Memory operand (signed for multiply/divide) |
| ac | output | W | Accumulator register |
| mq | output | W | Multiplier/quotient register |
| busy | output | 1 | High while an accepted operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Divide overflow / zero-divisor flag |

## Verification
The bench builds the block with `W`=4. At this width every multiplier and multiplicand pair (256 products) and every 8-bit dividend against every divisor (4096 divides) can be swept, and the expected value of each is computed with plain integer arithmetic. The sweep reaches every sign combination, the most-negative-by-minus-one overflow, all zero divisors, and quotients that sit exactly at the positive and negative range limits. This is width-independent control and correction logic that a 40-bit build could only sample.

// File: rtl/acmq_muldiv_pkg.sv
package acmq_muldiv_pkg;

    typedef enum logic [1:0] {
        OP_LDAC = 2'd0,
        OP_LDMQ = 2'd1,
        OP_MUL  = 2'd2,
        OP_DIV  = 2'd3
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2,
        ST_DONE = 2'd3
    } mdu_state_e;

endpackage

// File: rtl/acmq_muldiv_ctrl.sv
module acmq_muldiv_ctrl
    import acmq_muldiv_pkg::*;
#(
    parameter int W = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       arith_i,
    output mdu_state_e state_o,
    output logic       accept_o,
    output logic       step_o,
    output logic       fix_o,
    output logic       busy_o,
    output logic       done_o
);

    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mdu_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = arith_i ? ST_RUN : ST_DONE;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_FIX;
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN) cnt_q <= cnt_q + CW'(1);
            else                   cnt_q <= '0;
        end
    end

    // outputs decoded from the state
    always_comb begin
        state_o  = state_q;
        accept_o = 1'b0;
        step_o   = 1'b0;
        fix_o    = 1'b0;
        busy_o   = 1'b1;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = start_i;
            end
            ST_RUN:  step_o = 1'b1;
            ST_FIX:  fix_o  = 1'b1;
            ST_DONE: done_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/acmq_muldiv_prep.sv
module acmq_muldiv_prep #(
    parameter int W = 40
) (
    input  logic [W-1:0] ac_i,
    input  logic [W-1:0] mq_i,
    input  logic [W-1:0] opnd_i,
    input  logic         is_div_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] dsr_o,
    output logic         neg_res_o,
    output logic         neg_rem_o,
    output logic         pre_err_o
);

    localparam int DW = 2 * W;

    logic [DW-1:0] dvd, dvd_mag;
    logic [W-1:0]  mq_mag, op_mag;

    always_comb begin
        dvd     = {ac_i, mq_i};
        dvd_mag = ac_i[W-1]   ? -dvd   : dvd;
        mq_mag  = mq_i[W-1]   ? -mq_i  : mq_i;
        op_mag  = opnd_i[W-1] ? -opnd_i : opnd_i;
        dsr_o   = op_mag;
        if (is_div_i) begin
            hi_o      = dvd_mag[DW-1:W];
            lo_o      = dvd_mag[W-1:0];
            neg_res_o = ac_i[W-1] ^ opnd_i[W-1];
            neg_rem_o = ac_i[W-1];
            // unsigned quotient would need more than W bits (covers zero divisor)
            pre_err_o = (dvd_mag[DW-1:W] >= op_mag);
        end else begin
            hi_o      = '0;
            lo_o      = mq_mag;
            neg_res_o = mq_i[W-1] ^ opnd_i[W-1];
            neg_rem_o = 1'b0;
            pre_err_o = 1'b0;
        end
    end

endmodule

// File: rtl/acmq_muldiv_step.sv
module acmq_muldiv_step #(
    parameter int W = 40
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] dsr_i,
    input  logic         is_div_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);

    logic [W:0] sum, shl, diff, dsr_x;
    logic       ge;

    always_comb begin
        dsr_x = {1'b0, dsr_i};
        // multiply: add multiplicand when multiplier LSB set, then shift right
        sum   = {1'b0, hi_i} + (lo_i[0] ? dsr_x : '0);
        // divide: shift left, trial subtract
        shl   = {hi_i, lo_i[W-1]};
        diff  = shl - dsr_x;
        ge    = (shl >= dsr_x);
        if (is_div_i) begin
            hi_o = ge ? diff[W-1:0] : shl[W-1:0];
            lo_o = {lo_i[W-2:0], ge};
        end else begin
            hi_o = sum[W:1];
            lo_o = {sum[0], lo_i[W-1:1]};
        end
    end

endmodule

// File: rtl/acmq_muldiv_fix.sv
module acmq_muldiv_fix #(
    parameter int W = 40
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic         neg_res_i,
    input  logic         neg_rem_i,
    input  logic         is_div_i,
    output logic [W-1:0] ac_o,
    output logic [W-1:0] mq_o,
    output logic         range_err_o
);

    localparam int DW = 2 * W;
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic [DW-1:0] prod, prod_s;

    always_comb begin
        prod   = {hi_i, lo_i};
        prod_s = neg_res_i ? -prod : prod;
        if (is_div_i) begin
            range_err_o = neg_res_i ? (lo_i > HALF) : lo_i[W-1];
            mq_o        = neg_res_i ? -lo_i : lo_i;
            ac_o        = neg_rem_i ? -hi_i : hi_i;
        end else begin
            range_err_o = 1'b0;
            ac_o        = prod_s[DW-1:W];
            mq_o        = prod_s[W-1:0];
        end
    end

endmodule

// File: rtl/acmq_muldiv.sv
module acmq_muldiv
    import acmq_muldiv_pkg::*;
#(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] operand,
    output logic [W-1:0] ac,
    output logic [W-1:0] mq,
    output logic         busy,
    output logic         done,
    output logic         ovf
);

    mdu_state_e   state;
    logic         accept, step, fix;
    logic         op_div, op_arith;

    logic [W-1:0] ac_q, mq_q, hi_q, lo_q, dsr_q;
    logic         ovf_q, neg_res_q, neg_rem_q, div_q, err_q;

    logic [W-1:0] hi_init, lo_init, dsr_init, hi_nx, lo_nx, ac_fx, mq_fx;
    logic         neg_res_init, neg_rem_init, pre_err, range_err;

    assign op_div   = (op == OP_DIV);
    assign op_arith = (op == OP_MUL) || (op == OP_DIV);

    acmq_muldiv_ctrl #(.W(W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .arith_i  (op_arith),
        .state_o  (state),
        .accept_o (accept),
        .step_o   (step),
        .fix_o    (fix),
        .busy_o   (busy),
        .done_o   (done)
    );

    acmq_muldiv_prep #(.W(W)) prep_i (
        .ac_i      (ac_q),
        .mq_i      (mq_q),
        .opnd_i    (operand),
        .is_div_i  (op_div),
        .hi_o      (hi_init),
        .lo_o      (lo_init),
        .dsr_o     (dsr_init),
        .neg_res_o (neg_res_init),
        .neg_rem_o (neg_rem_init),
        .pre_err_o (pre_err)
    );

    acmq_muldiv_step #(.W(W)) step_i (
        .hi_i     (hi_q),
        .lo_i     (lo_q),
        .dsr_i    (dsr_q),
        .is_div_i (div_q),
        .hi_o     (hi_nx),
        .lo_o     (lo_nx)
    );

    acmq_muldiv_fix #(.W(W)) fix_i (
        .hi_i        (hi_q),
        .lo_i        (lo_q),
        .neg_res_i   (neg_res_q),
        .neg_rem_i   (neg_rem_q),
        .is_div_i    (div_q),
        .ac_o        (ac_fx),
        .mq_o        (mq_fx),
        .range_err_o (range_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_q      <= '0;
            mq_q      <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
            dsr_q     <= '0;
            ovf_q     <= 1'b0;
            neg_res_q <= 1'b0;
            neg_rem_q <= 1'b0;
            div_q     <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (accept) begin
                unique case (op)
                    OP_LDAC: ac_q <= operand;
                    OP_LDMQ: mq_q <= operand;
                    default: begin
                        hi_q      <= hi_init;
                        lo_q      <= lo_init;
                        dsr_q     <= dsr_init;
                        neg_res_q <= neg_res_init;
                        neg_rem_q <= neg_rem_init;
                        div_q     <= op_div;
                        err_q     <= pre_err;
                    end
                endcase
            end
            if (step) begin
                hi_q <= hi_nx;
                lo_q <= lo_nx;
            end
            if (fix) begin
                if (div_q && (err_q || range_err)) begin
                    ovf_q <= 1'b1;
                end else begin
                    ovf_q <= 1'b0;
                    ac_q  <= ac_fx;
                    mq_q  <= mq_fx;
                end
            end
        end
    end

    assign ac  = ac_q;
    assign mq  = mq_q;
    assign ovf = ovf_q;

    logic unused_state;
    assign unused_state = ^state;

endmodule

// File: rtl/acmq_muldiv_chk.sv
module acmq_muldiv_chk #(
    parameter int W = 40
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         ovf,
    input logic [W-1:0] ac,
    input logic [W-1:0] mq
);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_start_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_regs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (done || ($stable(ac) && $stable(mq))));

    assert_ovf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ovf));

endmodule

bind acmq_muldiv acmq_muldiv_chk #(.W(W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .ovf   (ovf),
    .ac    (ac),
    .mq    (mq)
);

// File: tb/acmq_muldiv_tb_top.sv
module acmq_muldiv_tb_top;

    localparam int W          = 4;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 1 << W;
    localparam int WDOG       = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = 2'd0;
    logic [W-1:0] operand = '0;
    logic [W-1:0] ac, mq;
    logic         busy, done, ovf;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    acmq_muldiv #(.W(W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op      (op),
        .operand (operand),
        .ac      (ac),
        .mq      (mq),
        .busy    (busy),
        .done    (done),
        .ovf     (ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
            summary();
        end
    end

    task automatic issue(input logic [1:0] o, input int v);
        @(negedge clk);
        start   = 1'b1;
        op      = o;
        operand = W'(v);
        @(negedge clk);
        start   = 1'b0;
    endtask

    // polls from the first cycle after the start edge; returns latency
    task automatic wait_done(output int lat, input int first, input bit hold_chk,
                             input logic [W-1:0] ac0, input logic [W-1:0] mq0);
        bit hold_ok = 1'b1;
        bit busy_ok = 1'b1;
        lat = first;
        while (!done && lat < 64) begin
            if (hold_chk && (ac !== ac0 || mq !== mq0)) hold_ok = 1'b0;
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        if (!busy) busy_ok = 1'b0;
        if (hold_chk) begin
            chk("R10 regs held while busy", hold_ok, 1);
            chk("R6 busy high through op", busy_ok, 1);
        end
        @(negedge clk);
        chk("R7 done single cycle", done, 0);
    endtask

    function automatic int sx(input int v, input int bits);
        return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
    endfunction

    initial begin
        int lat;
        logic [2*W-1:0] pb;
        bit prev_ovf;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ac after reset", ac, 0);
        chk("R1 mq after reset", mq, 0);
        chk("R1 busy after reset", busy, 0);
        chk("R1 done after reset", done, 0);
        chk("R1 ovf after reset", ovf, 0);
        rst_n = 1'b1;

        // R2 loads
        issue(2'd0, 5);
        wait_done(lat, 1, 1'b0, '0, '0);
        chk("R2 load AC latency", lat, 1);
        chk("R2 load AC value", ac, 5);
        issue(2'd1, 9);
        wait_done(lat, 1, 1'b0, '0, '0);
        chk("R2 load MQ latency", lat, 1);
        chk("R2 load MQ value", mq, 9);
        chk("R2 load MQ leaves AC", ac, 5);

        // R8 start ignored while busy: 3 * 5 = 15
        issue(2'd1, 3);
        wait_done(lat, 1, 1'b0, '0, '0);
        issue(2'd2, 5);
        @(negedge clk);
        start = 1'b1; op = 2'd0; operand = W'(9);
        @(negedge clk);
        start = 1'b0;
        wait_done(lat, 3, 1'b0, '0, '0);
        chk("R8 latency with ignored start", lat, W + 2);
        chk("R8 ac not overwritten", ac, 0);
        chk("R8 mq product", mq, 15);

        // R3 multiply sweep
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                issue(2'd1, b);
                wait_done(lat, 1, 1'b0, '0, '0);
                issue(2'd2, a);
                wait_done(lat, 1, 1'b1, ac, W'(b));
                pb = (2*W)'(sx(a, W) * sx(b, W));
                chk("R6 multiply latency", lat, W + 2);
                chk("R3 product high in AC", ac, pb[2*W-1:W]);
                chk("R3 product low in MQ", mq, pb[W-1:0]);
                chk("R3 ovf clear", ovf, 0);
            end
        end

        // R4/R5 divide sweep
        prev_ovf = ovf;
        for (int x = 0; x < N; x++) begin
            for (int y = 0; y < N; y++) begin
                for (int d = 0; d < N; d++) begin
                    int dv, sd, q, r;
                    bit bad;
                    issue(2'd0, x);
                    wait_done(lat, 1, 1'b0, '0, '0);
                    issue(2'd1, y);
                    wait_done(lat, 1, 1'b0, '0, '0);
                    chk("R9 ovf kept by loads", ovf, prev_ovf);
                    issue(2'd3, d);
                    wait_done(lat, 1, 1'b1, W'(x), W'(y));
                    chk("R6 divide latency", lat, W + 2);
                    dv = sx(x * N + y, 2 * W);
                    sd = sx(d, W);
                    bad = (sd == 0);
                    q = 0; r = 0;
                    if (!bad) begin
                        q = dv / sd;
                        r = dv % sd;
                        bad = (q > (N/2 - 1)) || (q < -(N/2));
                    end
                    if (bad) begin
                        chk("R5 ovf set", ovf, 1);
                        chk("R5 AC unchanged", ac, x);
                        chk("R5 MQ unchanged", mq, y);
                    end else begin
                        chk("R4 ovf clear", ovf, 0);
                        chk("R4 quotient in MQ", mq, q & (N - 1));
                        chk("R4 remainder in AC", ac, r & (N - 1));
                    end
                    prev_ovf = bad;
                end
            end
        end

        finished = 1'b1;
        summary();
    end

endmodule